// File: doc/BRIEF.md
# Cascadable Dual Timer with Trigger Gating

This block holds two 8-bit timer channels. Each channel counts the pulses of one clock-enable line picked from a bus of eight, and compares its count with a period value. When a counting tick arrives while the count equals the period, the count returns to zero, the channel's interrupt pulses for one cycle and its toggle output flips. In auto-reload mode the channel then keeps counting. In one-shot mode it halts at that point.

Counting starts and stops in one of two ways. Software can pulse start and stop inputs. Or, when trigger gating is enabled, an external trigger line controls it after a two-stage synchroniser and a three-cycle width filter. A filtered rising edge clears the count and starts it, and the filtered falling edge stops it. The count left behind is the width of the pulse, measured in selected ticks.

When the pairing input is set, the two channels act as a single 16-bit timer. The lower channel's carry advances the upper channel, the full 16-bit count is compared with both period fields together, and only the upper channel's interrupt and toggle respond. Pin multiplexing and analog trigger sources sit outside this block.

Top module: `pair_timer`

## Requirements
- R1: After reset, count_o, irq_o and tog_o are all zero, and both channels are stopped.
- R2: While a channel runs, each selected tick raises its count by one. A tick that arrives with the count equal to the channel's period field returns the count to 0 and drives that channel's irq_o bit high for exactly the following cycle. In auto-reload mode (oneshot_i bit 0), counting then continues, so one period lasts period+1 ticks.
- R3: Channel c counts only the tick_i line whose index is the 3-bit field csel_i[3c+2:3c]. Pulses on the other tick_i lines have no effect on its count.
- R4: With trigger gating off, a pulse on start_i[c] clears channel c's count to 0 and starts it, and start wins over any stop or match in the same cycle. A pulse on stop_i[c] halts counting, and the count then holds.
- R5: With oneshot_i[c]=1, the match that returns the count to 0 also stops the channel, and the count stays at 0 until the next start.
- R6: With pair_i=1, {count_o[15:8],count_o[7:0]} forms one 16-bit counter driven by channel 0's run state and tick. The low byte wraps from 0xFF and carries into the high byte. The match compares against {period_i[15:8],period_i[7:0]}. irq_o[0] stays 0 and only irq_o[1] pulses.
- R7: Each trigger_i[c] passes through two synchronising flops. A change of level is accepted only after the synchronised value has held for three consecutive core-clock cycles, so a pulse of two cycles or fewer has no effect on the count.
- R8: With trig_en_i[c]=1, an accepted trigger rise clears channel c's count and starts it, and an accepted fall stops it. For a trigger pulse N core cycles wide with a tick every cycle and a period of 255, the count left behind equals N.
- R9: tog_o[c] inverts in exactly the cycles in which irq_o[c] is high, and holds in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 8 | Clock-enable source bus, one line per prescaled rate |
| csel_i | input | 6 | Per-channel tick line select, 3 bits each |
| period_i | input | 16 | Per-channel period (match) value, 8 bits each |
| oneshot_i | input | 2 | Per-channel mode: 1 one-shot, 0 auto-reload |
| trig_en_i | input | 2 | Per-channel trigger gating enable |
| start_i | input | 2 | Per-channel software start pulse |
| stop_i | input | 2 | Per-channel software stop pulse |
| pair_i | input | 1 | Joins the two channels into one 16-bit timer |
| trigger_i | input | 2 | Per-channel asynchronous external trigger |
| count_o | output | 16 | Current counts, channel 1 in the upper byte |
| irq_o | output | 2 | One-cycle match interrupt per channel |
| tog_o | output | 2 | Toggle output per channel |

## Verification
The count is tried with four stimulus kinds. A steady tick on a short period exposes off-by-one errors in the wrap point and the interrupt timing. A sparse tick on a second line, with the first line held high, shows whether the source select really excludes the unselected lines. A long paired run across the 0xFF to 0x100 carry and up to the 16-bit match separates a true 16-bit compare from two independent byte matches. Trigger pulses of seven, two and three cycles show whether the filter threshold and the measured width are exact.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_CLR  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/pt_trig_filt.sv
module pt_trig_filt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HW = HOLD_CYCLES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hist_q, hist_d;
  logic [HOLD_CYCLES-1:0] window;
  logic                   lvl_q, lvl_d, rise_q, fall_q;

  always_comb begin
    window = {hist_q, sync_q[SYNC_STAGES-1]};
    hist_d = window[HW-1:0];
    if (&window)       lvl_d = 1'b1;
    else if (~|window) lvl_d = 1'b0;
    else               lvl_d = lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q <= hist_d;
      lvl_q  <= lvl_d;
      rise_q <= lvl_d & ~lvl_q;
      fall_q <= ~lvl_d & lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/pt_run_ctl.sv
module pt_run_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_ev_i,
  input  logic stop_ev_i,
  input  logic os_stop_i,
  output logic run_o
);
  logic run_q, run_d;

  always_comb begin
    if (start_ev_i)                  run_d = 1'b1;
    else if (stop_ev_i || os_stop_i) run_d = 1'b0;
    else                             run_d = run_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  assign run_o = run_q;
endmodule

// File: rtl/pt_count.sv
module pt_count
  import pt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_act_e     act_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case (act_i)
      ACT_CLR: cnt_d = '0;
      ACT_INC: cnt_d = cnt_q + W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pair_timer.sv
module pair_timer
  import pt_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned NSRC = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NSRC-1:0]               tick_i,
  input  logic [2*$clog2(NSRC)-1:0]     csel_i,
  input  logic [2*W-1:0]                period_i,
  input  logic [1:0]                    oneshot_i,
  input  logic [1:0]                    trig_en_i,
  input  logic [1:0]                    start_i,
  input  logic [1:0]                    stop_i,
  input  logic                          pair_i,
  input  logic [1:0]                    trigger_i,
  output logic [2*W-1:0]                count_o,
  output logic [1:0]                    irq_o,
  output logic [1:0]                    tog_o
);
  localparam int unsigned NCH   = 2;
  localparam int unsigned SEL_W = $clog2(NSRC);

  logic [NCH-1:0] tick_sel, run, rise, fall, lvl;
  logic [NCH-1:0] start_ev, stop_ev, os_stop, ce, match8, hit;
  logic [W-1:0]   cnt [NCH];
  logic [W-1:0]   per [NCH];
  cnt_act_e       act [NCH];
  logic           match16, hit_pair, carry, full_lo;
  logic [NCH-1:0] irq_q, tog_q, tog_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign per[c]      = period_i[c*W +: W];
    assign tick_sel[c] = tick_i[csel_i[c*SEL_W +: SEL_W]];
    assign start_ev[c] = trig_en_i[c] ? rise[c] : start_i[c];
    assign stop_ev[c]  = trig_en_i[c] ? fall[c] : stop_i[c];
    assign count_o[c*W +: W] = cnt[c];

    pt_trig_filt #(.SYNC_STAGES(2), .HOLD_CYCLES(3)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (trigger_i[c]),
      .lvl_o  (lvl[c]),
      .rise_o (rise[c]),
      .fall_o (fall[c])
    );

    pt_run_ctl u_run (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_ev_i (start_ev[c]),
      .stop_ev_i  (stop_ev[c]),
      .os_stop_i  (os_stop[c]),
      .run_o      (run[c])
    );

    pt_count #(.W(W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (act[c]),
      .cnt_o  (cnt[c])
    );
  end

  // Match, carry and counter actions for both the single and paired modes
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ce[c]     = run[c] & tick_sel[c];
      match8[c] = (cnt[c] == per[c]);
    end
    full_lo  = &cnt[0];
    match16  = ({cnt[1], cnt[0]} == {per[1], per[0]});
    hit_pair = ce[0] & match16;
    carry    = ce[0] & full_lo & ~match16;

    hit[0] = ~pair_i & ce[0] & match8[0];
    hit[1] = pair_i ? hit_pair : (ce[1] & match8[1]);

    os_stop[0] = oneshot_i[0] & (pair_i ? hit_pair : hit[0]);
    os_stop[1] = ~pair_i & oneshot_i[1] & hit[1];

    if (start_ev[0] || hit[0] || (pair_i && hit_pair)) act[0] = ACT_CLR;
    else if (ce[0])                                    act[0] = ACT_INC;
    else                                               act[0] = ACT_HOLD;

    if (pair_i) begin
      if (start_ev[0] || hit_pair) act[1] = ACT_CLR;
      else if (carry)              act[1] = ACT_INC;
      else                         act[1] = ACT_HOLD;
    end else begin
      if (start_ev[1] || hit[1])   act[1] = ACT_CLR;
      else if (ce[1])              act[1] = ACT_INC;
      else                         act[1] = ACT_HOLD;
    end

    tog_d = tog_q ^ hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      tog_q <= '0;
    end else begin
      irq_q <= hit;
      tog_q <= tog_d;
    end
  end

  assign irq_o = irq_q;
  assign tog_o = tog_q;
endmodule

// File: rtl/pair_timer_chk.sv
module pair_timer_chk #(
  parameter int unsigned W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [1:0]     oneshot_i,
  input logic [1:0]     trig_en_i,
  input logic [1:0]     start_i,
  input logic           pair_i,
  input logic [2*W-1:0] count_o,
  input logic [1:0]     irq_o,
  input logic [1:0]     tog_o
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    // R2: an interrupt cycle always shows the count back at zero
    a_r2_irq_count_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (count_o[c*W +: W] == '0));

    // R5: after a one-shot match the count stays at zero
    a_r5_oneshot_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[c] && $past(oneshot_i[c]) && !start_i[c] && !trig_en_i[c]
       && !pair_i && !$past(pair_i)) |=> (count_o[c*W +: W] == '0));

    // R9: toggle flips with each interrupt
    a_r9_tog_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (tog_o[c] != $past(tog_o[c])));

    // R9: toggle holds without an interrupt
    a_r9_tog_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o[c] |-> $stable(tog_o[c]));
  end

  // R6: the lower channel raises no interrupt while paired
  a_r6_low_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_i |=> !irq_o[0]);
endmodule

bind pair_timer pair_timer_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oneshot_i (oneshot_i),
  .trig_en_i (trig_en_i),
  .start_i   (start_i),
  .pair_i    (pair_i),
  .count_o   (count_o),
  .irq_o     (irq_o),
  .tog_o     (tog_o)
);

// File: tb/tb_pair_timer.sv
module tb_pair_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  tick;
  logic [5:0]  csel;
  logic [15:0] period;
  logic [1:0]  oneshot, trig_en, start, stop, trig;
  logic        pair;
  logic [15:0] count;
  logic [1:0]  irq, tog;
  int          nvec = 0;
  int          nerr = 0;

  always #10 clk = ~clk;

  pair_timer dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .csel_i    (csel),
    .period_i  (period),
    .oneshot_i (oneshot),
    .trig_en_i (trig_en),
    .start_i   (start),
    .stop_i    (stop),
    .pair_i    (pair),
    .trigger_i (trig),
    .count_o   (count),
    .irq_o     (irq),
    .tog_o     (tog)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input int c);
    @(negedge clk); start[c] = 1'b1;
    @(negedge clk); start[c] = 1'b0;
  endtask

  task automatic pulse_stop(input int c);
    @(negedge clk); stop[c] = 1'b1;
    @(negedge clk); stop[c] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "count", count, 16'h0);
    chk("R1", "irq", {14'h0, irq}, 16'h0);
    chk("R1", "tog", {14'h0, tog}, 16'h0);
  endtask

  task automatic t_autoreload();
    logic [15:0] held;
    csel[2:0] = 3'd0; period[7:0] = 8'd4; oneshot[0] = 1'b0;
    pulse_start(0);
    chk("R4", "count after start", {8'h0, count[7:0]}, 16'h0);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk("R2", "reload count", {8'h0, count[7:0]}, 16'(k % 5));
      if (k == 5) begin
        chk("R2", "irq at wrap", {15'h0, irq[0]}, 16'h1);
        chk("R9", "tog after first wrap", {15'h0, tog[0]}, 16'h1);
      end
      if (k == 6) chk("R2", "irq one cycle", {15'h0, irq[0]}, 16'h0);
      if (k == 10) chk("R9", "tog after second wrap", {15'h0, tog[0]}, 16'h0);
    end
    pulse_stop(0);
    held = count;
    repeat (6) @(negedge clk);
    chk("R4", "count holds after stop", count, held);
  endtask

  task automatic t_clksel();
    csel[2:0] = 3'd1; period[7:0] = 8'hFF;
    pulse_start(0);
    chk("R4", "start clears nonzero count", {8'h0, count[7:0]}, 16'h0);
    for (int k = 0; k <= 20; k++) begin
      tick[1] = (k % 3 == 0);
      @(negedge clk);
    end
    tick[1] = 1'b0;
    pulse_stop(0);
    chk("R3", "only selected line counted", {8'h0, count[7:0]}, 16'd7);
    csel[2:0] = 3'd0;
  endtask

  task automatic t_oneshot();
    period[7:0] = 8'd3; oneshot[0] = 1'b1;
    pulse_start(0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k < 4) chk("R5", "one-shot counting", {8'h0, count[7:0]}, 16'(k));
      if (k == 4) begin
        chk("R5", "one-shot wrap count", {8'h0, count[7:0]}, 16'h0);
        chk("R5", "one-shot irq", {15'h0, irq[0]}, 16'h1);
      end
      if (k == 8) begin
        chk("R5", "one-shot stays halted", {8'h0, count[7:0]}, 16'h0);
        chk("R5", "no second irq", {15'h0, irq[0]}, 16'h0);
      end
    end
    oneshot[0] = 1'b0;
  endtask

  task automatic t_pair();
    pair = 1'b1; period = 16'h0102;
    pulse_start(0);
    for (int k = 1; k <= 260; k++) begin
      @(negedge clk);
      if (k == 2)   chk("R6", "low byte match ignored", {15'h0, irq[0]}, 16'h0);
      if (k == 255) chk("R6", "count 0xFF", count, 16'h00FF);
      if (k == 256) begin
        chk("R6", "carry to high byte", count, 16'h0100);
        chk("R6", "low wrap no irq", {15'h0, irq[0]}, 16'h0);
      end
      if (k == 258) chk("R6", "count at period", count, 16'h0102);
      if (k == 259) begin
        chk("R6", "16-bit wrap", count, 16'h0000);
        chk("R6", "upper irq", {14'h0, irq}, 16'h2);
      end
    end
    pulse_stop(0);
    pair = 1'b0;
  endtask

  task automatic trig_pulse(input int n);
    @(negedge clk); trig[1] = 1'b1;
    repeat (n) @(negedge clk);
    trig[1] = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_trigger();
    period[15:8] = 8'hFF; csel[5:3] = 3'd0; trig_en[1] = 1'b1;
    trig_pulse(7);
    chk("R8", "width of 7-cycle pulse", {8'h0, count[15:8]}, 16'd7);
    trig_pulse(2);
    chk("R7", "2-cycle pulse ignored", {8'h0, count[15:8]}, 16'd7);
    trig_pulse(3);
    chk("R7", "3-cycle pulse accepted", {8'h0, count[15:8]}, 16'd3);
    trig_en[1] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 8'h01; csel = '0; period = '0; oneshot = '0;
    trig_en = '0; start = '0; stop = '0; trig = '0; pair = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_autoreload();
    t_clksel();
    t_oneshot();
    t_pair();
    t_trigger();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule